// File: doc/BRIEF.md
# Microcoded Control Sequencer with Table-Selected Next State

This block is the control unit of a multicycle processor. A state register holds the current microstate. That state indexes a main table of control words, and the control word drives every datapath control line in the same cycle. The control word also says where the following microstate comes from. It can be the word's own next-state field. It can be an entry of an opcode-dispatch table indexed by the instruction opcode, which is used when fetch ends. It can be an entry of a two-entry branch table indexed by the zero flag, which is used by the conditional branch. A 2-bit source select, formed from two test bits in the control word, steers a multiplexer that feeds the state register.

The state register advances only on cycles where step enable is high and no table write is in progress, so the unit can be single-stepped. All three tables are loaded through a shared write port (select, address, data). Setting both test bits in one word is illegal. In that case the state freezes and an error output is raised.

Top module: `uctl_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge the state becomes 0. After release, and before any step, the control outputs show main-table entry 0.
- R2: The control outputs come from the main-table word at the current state, with these bit positions: `drive_en` = bits 10:6, `load_en` = bits 16:11, `write_en` = bits 18:17, `reg_sel` = bits 20:19, `alu_fn` = bits 22:21.
- R3: On an advancing edge where word bits 23 (opcode test) and 24 (zero test) are both 0, the next state is word bits 5:0.
- R4: On an advancing edge where only bit 23 is set, the next state is the opcode-table entry at index `opcode`. The word's own bits 5:0 are not used.
- R5: On an advancing edge where only bit 24 is set, the next state is the branch-table entry at address {0, `z_flag`}. Branch-table addresses 2 and 3 are never read.
- R6: When bits 23 and 24 are both set, `sel_err` is 1 and the state does not change on any edge.
- R7: When `step_en` is 0 the state does not change.
- R8: While `tbl_we` is 1 the state does not change. The write goes to the main table when `tbl_sel`=0, to the opcode table when `tbl_sel`=1 and to the branch table when `tbl_sel`=2. A write with `tbl_sel`=3 changes no table. Main-table writes show on the outputs at once if they hit the current state.
- R9: `sel_err` is 0 whenever the current word does not set both test bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Allows the state to advance |
| opcode | input | 3 | Instruction opcode for dispatch |
| z_flag | input | 1 | Zero flag for branch decisions |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Target table: 0 main, 1 opcode, 2 branch, 3 none |
| tbl_addr | input | 6 | Table write address |
| tbl_wdata | input | 25 | Table write data |
| drive_en | output | 5 | Bus drive enables (register file, memory, ALU, PC, offset) |
| load_en | output | 6 | Register load enables (PC, IR, MAR, A, B, Z) |
| write_en | output | 2 | Register-file write, memory write |
| reg_sel | output | 2 | Register field select |
| alu_fn | output | 2 | ALU function code |
| state_q | output | 6 | Current microstate |
| sel_err | output | 1 | Both next-state test bits set |

## Verification
On every cycle the assertions check that the state moves to the entry named by the active source (word field, opcode table or branch table), and that it stays put when the unit is not stepping, when a write is pending, or when both test bits are set. Only the bench scenarios can show the rest. These are the bit positions of the decoded outputs, whether the loaded tables hold the intended contents, that a write with select 3 leaves every table untouched, that the unused branch entries are never reached, and that full microprogram walks return to state 0.

// File: rtl/uctl_pkg.sv
package uctl_pkg;

  // Source of the next microstate, encoded as {zero test, opcode test}.
  typedef enum logic [1:0] {
    SRC_WORD = 2'b00,
    SRC_OP   = 2'b01,
    SRC_ZT   = 2'b10,
    SRC_BAD  = 2'b11
  } nsrc_e;

  // Table targeted by the write port.
  typedef enum logic [1:0] {
    TBL_MAIN = 2'd0,
    TBL_OP   = 2'd1,
    TBL_ZT   = 2'd2,
    TBL_NONE = 2'd3
  } tsel_e;

  function automatic nsrc_e next_src(input logic op_test, input logic z_test);
    return nsrc_e'({z_test, op_test});
  endfunction

  function automatic logic tbl_hit(input logic we, input logic [1:0] sel,
                                   input tsel_e want);
    return we && (sel == want);
  endfunction

endpackage

// File: rtl/uctl_table.sv
module uctl_table #(
  parameter int W  = 25,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/uctl_next_sel.sv
module uctl_next_sel
  import uctl_pkg::*;
#(
  parameter int SW = 6
) (
  input  nsrc_e         src,
  input  logic [SW-1:0] cur,
  input  logic [SW-1:0] from_word,
  input  logic [SW-1:0] from_op,
  input  logic [SW-1:0] from_zt,
  output logic [SW-1:0] nxt,
  output logic          conflict
);

  always_comb begin
    conflict = 1'b0;
    unique case (src)
      SRC_WORD: nxt = from_word;
      SRC_OP:   nxt = from_op;
      SRC_ZT:   nxt = from_zt;
      default: begin
        nxt      = cur;
        conflict = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/uctl_state_reg.sv
module uctl_state_reg #(
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [SW-1:0] nxt,
  output logic [SW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (adv) q <= nxt;
  end

  // R7 R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(q));

endmodule

// File: rtl/uctl_sequencer.sv
module uctl_sequencer
  import uctl_pkg::*;
#(
  parameter int STATE_W = 6,
  parameter int OP_W    = 3,
  parameter int ZT_AW   = 2,
  localparam int DRV_W  = 5,
  localparam int LD_W   = 6,
  localparam int CW_W   = STATE_W + DRV_W + LD_W + 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_en,
  input  logic [OP_W-1:0]    opcode,
  input  logic               z_flag,
  input  logic               tbl_we,
  input  logic [1:0]         tbl_sel,
  input  logic [STATE_W-1:0] tbl_addr,
  input  logic [CW_W-1:0]    tbl_wdata,
  output logic [DRV_W-1:0]   drive_en,
  output logic [LD_W-1:0]    load_en,
  output logic [1:0]         write_en,
  output logic [1:0]         reg_sel,
  output logic [1:0]         alu_fn,
  output logic [STATE_W-1:0] state_q,
  output logic               sel_err
);

  localparam int DRV_LSB = STATE_W;
  localparam int LD_LSB  = DRV_LSB + DRV_W;
  localparam int WR_LSB  = LD_LSB + LD_W;
  localparam int RS_LSB  = WR_LSB + 2;
  localparam int ALU_LSB = RS_LSB + 2;
  localparam int OPT_BIT = ALU_LSB + 2;
  localparam int CHZ_BIT = OPT_BIT + 1;

  // Named internal events
  logic [CW_W-1:0]    cw;
  logic [STATE_W-1:0] op_entry;
  logic [STATE_W-1:0] zt_entry;
  logic [STATE_W-1:0] nxt_state;
  logic [ZT_AW-1:0]   zt_raddr;
  logic               we_main, we_op, we_zt;
  logic               adv;
  logic               op_test, z_test;
  logic               conflict;
  nsrc_e              src;

  assign we_main  = tbl_hit(tbl_we, tbl_sel, TBL_MAIN);
  assign we_op    = tbl_hit(tbl_we, tbl_sel, TBL_OP);
  assign we_zt    = tbl_hit(tbl_we, tbl_sel, TBL_ZT);
  assign zt_raddr = {{(ZT_AW-1){1'b0}}, z_flag};
  assign adv      = step_en && !tbl_we;

  uctl_table #(.W(CW_W), .AW(STATE_W)) u_main (
    .clk(clk), .we(we_main), .waddr(tbl_addr), .wdata(tbl_wdata),
    .raddr(state_q), .rdata(cw)
  );

  uctl_table #(.W(STATE_W), .AW(OP_W)) u_optbl (
    .clk(clk), .we(we_op), .waddr(tbl_addr[OP_W-1:0]),
    .wdata(tbl_wdata[STATE_W-1:0]), .raddr(opcode), .rdata(op_entry)
  );

  uctl_table #(.W(STATE_W), .AW(ZT_AW)) u_zttbl (
    .clk(clk), .we(we_zt), .waddr(tbl_addr[ZT_AW-1:0]),
    .wdata(tbl_wdata[STATE_W-1:0]), .raddr(zt_raddr), .rdata(zt_entry)
  );

  assign op_test = cw[OPT_BIT];
  assign z_test  = cw[CHZ_BIT];
  assign src     = next_src(op_test, z_test);

  uctl_next_sel #(.SW(STATE_W)) u_nsel (
    .src(src), .cur(state_q), .from_word(cw[STATE_W-1:0]),
    .from_op(op_entry), .from_zt(zt_entry),
    .nxt(nxt_state), .conflict(conflict)
  );

  uctl_state_reg #(.SW(STATE_W)) u_sreg (
    .clk(clk), .rst(rst), .adv(adv), .nxt(nxt_state), .q(state_q)
  );

  assign drive_en = cw[DRV_LSB +: DRV_W];
  assign load_en  = cw[LD_LSB +: LD_W];
  assign write_en = cw[WR_LSB +: 2];
  assign reg_sel  = cw[RS_LSB +: 2];
  assign alu_fn   = cw[ALU_LSB +: 2];
  assign sel_err  = conflict;

  // R3
  word_next_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !op_test && !z_test) |=> state_q == $past(cw[STATE_W-1:0]));

  // R4
  op_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && op_test && !z_test) |=> state_q == $past(op_entry));

  // R5
  zero_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && z_test && !op_test) |=> state_q == $past(zt_entry));

  // R6
  conflict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_test && z_test) |=> state_q == $past(state_q));

endmodule

// File: tb/test_uctl_sequencer.sv
module test_uctl_sequencer;

  logic        clk = 1'b0;
  logic        rst;
  logic        step_en;
  logic [2:0]  opcode;
  logic        z_flag;
  logic        tbl_we;
  logic [1:0]  tbl_sel;
  logic [5:0]  tbl_addr;
  logic [24:0] tbl_wdata;
  logic [4:0]  drive_en;
  logic [5:0]  load_en;
  logic [1:0]  write_en;
  logic [1:0]  reg_sel;
  logic [1:0]  alu_fn;
  logic [5:0]  state_q;
  logic        sel_err;

  always #10 clk = ~clk;

  uctl_sequencer i_uctl_sequencer (
    .clk(clk), .rst(rst), .step_en(step_en), .opcode(opcode), .z_flag(z_flag),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .drive_en(drive_en), .load_en(load_en), .write_en(write_en),
    .reg_sel(reg_sel), .alu_fn(alu_fn), .state_q(state_q), .sel_err(sel_err)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [24:0] m_main [64];
  logic [5:0]  m_op   [8];
  logic [5:0]  m_zt   [4];
  logic [5:0]  m_st;

  typedef struct {
    logic [5:0]  st;
    logic [24:0] cw;
    string       req;
  } exp_t;
  exp_t sbq[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2: outputs regrouped from the expected word: {alu,rsel,wr,ld,drv}
  function automatic logic [16:0] out_of(input logic [24:0] w);
    return w[22:6];
  endfunction

  function automatic logic [16:0] out_now();
    return {alu_fn, reg_sel, write_en, load_en, drive_en};
  endfunction

  function automatic logic [24:0] mkword(input int i);
    logic [16:0] ctl;
    ctl = 17'((i * 40503 + 7) ^ (i << 5));
    return {2'b00, ctl, 6'((i + 1) % 64)};
  endfunction

  // Monitor: samples 5 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        chk(state_q === e.st, {e.req, " state"}, 64'(state_q), 64'(e.st));
        chk(out_now() === out_of(e.cw), {"R2 ", e.req, " outputs"},
            64'(out_now()), 64'(out_of(e.cw)));
      end
    end
  end

  task automatic tbl_write(input logic [1:0] sel, input logic [5:0] addr,
                           input logic [24:0] data);
    tbl_sel = sel; tbl_addr = addr; tbl_wdata = data; tbl_we = 1'b1;
    case (sel)
      2'd0: m_main[addr] = data;
      2'd1: m_op[addr[2:0]] = data[5:0];
      2'd2: m_zt[addr[1:0]] = data[5:0];
      default: ;
    endcase
    if (!rst) sbq.push_back('{m_st, m_main[m_st], "R8"});
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic cycle(input logic step, input logic [2:0] op, input logic z,
                       input string req);
    logic [5:0] nx;
    logic       bad;
    step_en = step; opcode = op; z_flag = z;
    #1;
    bad = m_main[m_st][23] & m_main[m_st][24];
    chk(sel_err === bad, bad ? "R6 sel_err" : "R9 sel_err",
        64'(sel_err), 64'(bad));
    if (bad)                 nx = m_st;
    else if (m_main[m_st][23]) nx = m_op[op];
    else if (m_main[m_st][24]) nx = m_zt[{1'b0, z}];
    else                     nx = m_main[m_st][5:0];
    if (step) m_st = nx;
    sbq.push_back('{m_st, m_main[m_st], req});
    @(negedge clk);
  endtask

  task automatic run_to_zero(input logic [2:0] op, input logic z, input string req);
    for (int k = 0; k < 100; k++) begin
      cycle(1'b1, op, z, req);
      if (m_st == 6'd0) break;
    end
  endtask

  initial begin
    rst = 1'b1; step_en = 1'b0; opcode = '0; z_flag = 1'b0;
    tbl_we = 1'b0; tbl_sel = '0; tbl_addr = '0; tbl_wdata = '0;
    m_st = '0;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      logic [24:0] w;
      w = mkword(i);
      if (i == 3)  w = {2'b01, w[22:6], 6'd60};
      if (i == 10) w = {2'b10, w[22:6], 6'd61};
      if (i == 20) w = {2'b11, w[22:6], 6'd0};
      if (i == 45 || i == 55) w[5:0] = 6'd0;
      tbl_write(2'd0, 6'(i), w);
    end
    begin
      int seq_v[8] = '{32, 10, 32, 38, 20, 35, 40, 37};
      for (int i = 0; i < 8; i++) tbl_write(2'd1, 6'(i), 25'(seq_v[i]));
    end
    tbl_write(2'd2, 6'd0, 25'd40);
    tbl_write(2'd2, 6'd1, 25'd50);
    tbl_write(2'd2, 6'd2, 25'd5);
    tbl_write(2'd2, 6'd3, 25'd6);
    rst = 1'b0;
    #1;
    // R1: reset state and entry-0 outputs
    chk(state_q === 6'd0, "R1 reset state", 64'(state_q), 64'd0);
    chk(out_now() === out_of(m_main[0]), "R1 reset outputs",
        64'(out_now()), 64'(out_of(m_main[0])));
    @(negedge clk);

    run_to_zero(3'd2, 1'b0, "R4 dispatch op2 / R3");
    run_to_zero(3'd7, 1'b1, "R4 dispatch op7 / R3");
    run_to_zero(3'd1, 1'b0, "R5 branch not taken");
    run_to_zero(3'd1, 1'b1, "R5 branch taken");
    // R7: step disabled mid-walk
    cycle(1'b1, 3'd0, 1'b0, "R3");
    cycle(1'b1, 3'd0, 1'b0, "R3");
    for (int k = 0; k < 3; k++) cycle(1'b0, 3'd5, 1'b1, "R7 hold");
    cycle(1'b1, 3'd4, 1'b0, "R3");
    cycle(1'b1, 3'd4, 1'b0, "R4 to conflict");
    // R6: conflicting word at state 20 freezes
    for (int k = 0; k < 3; k++) cycle(1'b1, 3'd4, 1'b1, "R6 hold");
    // R8: select 3 writes nowhere, state held during writes
    step_en = 1'b1;
    tbl_write(2'd3, 6'd20, 25'h0ABCDE);
    tbl_write(2'd3, 6'd4, 25'h1F0F0F);
    cycle(1'b1, 3'd4, 1'b0, "R8 sel3 ignored / R6");
    // R8: rewrite current word; visible at once, state held
    tbl_write(2'd0, 6'd20, {2'b00, 17'h15A5A, 6'd0});
    tbl_write(2'd1, 6'd4, 25'd12);
    cycle(1'b1, 3'd4, 1'b0, "R3 after rewrite");
    // R8: opcode-table rewrite used on next dispatch
    run_to_zero(3'd4, 1'b0, "R8 rewritten op entry");
    // R1: reset mid-run
    cycle(1'b1, 3'd0, 1'b0, "R3");
    rst = 1'b1; m_st = 6'd0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(state_q === 6'd0, "R1 reset mid-run", 64'(state_q), 64'd0);
    @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule